// File: doc/BRIEF.md
# Pipelined RGB to YCbCr Colour Converter

This block turns one unsigned 8-bit RGB pixel per clock into unsigned 8-bit luma (Y) and blue/red chroma (Cb, Cr) samples. Each output channel is a weighted sum of the three inputs. The weights are signed fixed-point constants with 14 fractional bits, built from constant multipliers and an adder tree. Both chroma channels are biased by 128, so a neutral grey lands at mid-scale.

A producer presents a pixel together with a valid strobe. The matching result leaves with its own valid strobe exactly three clocks later. The three register stages are product, sum and round/clamp, and a new pixel may enter on every clock. Each pipeline stage loads only when valid data reaches it. When the output valid is low, the output samples therefore keep the last converted pixel. Chroma subsampling, DCT level shifting and the transform itself belong to other blocks.

Top module: `rgb2ycc_conv`

## Requirements
- R1: Y equals floor((4899·R + 9617·G + 1868·B + 8192) / 16384), clamped to 0..255.
- R2: out_valid is high exactly three clock cycles after each cycle in which in_valid is high, and low otherwise.
- R3: Cb equals floor((−2764·R − 5428·G + 8192·B + 128·16384 + 8192) / 16384), clamped to 0..255.
- R4: Cr equals floor((8192·R − 6860·G − 1332·B + 128·16384 + 8192) / 16384), clamped to 0..255.
- R5: Any channel result above 255 is output as 255 and any result below 0 is output as 0. For example, pure blue (0,0,255) gives Cb = 255, and pure red gives Cr = 255.
- R6: While out_valid is low, out_y, out_cb and out_cr keep the values of the most recent converted pixel. An input presented with in_valid low does not change them.
- R7: After reset, out_valid, out_y, out_cb and out_cr are all 0.
- R8: A grey input with R = G = B = v yields Y = v and Cb = Cr = 128.
- R9: Pixels presented on consecutive cycles each produce their own result on consecutive cycles, in input order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Pixel on in_r/in_g/in_b is present this cycle |
| in_r | input | 8 | Red component, unsigned |
| in_g | input | 8 | Green component, unsigned |
| in_b | input | 8 | Blue component, unsigned |
| out_valid | output | 1 | out_y/out_cb/out_cr carry a new result |
| out_y | output | 8 | Luma result |
| out_cb | output | 8 | Blue-difference chroma result |
| out_cr | output | 8 | Red-difference chroma result |

## Verification
Two functions can meet in one cycle. A result can reach the saturation limit in the same cycle that a bubble follows it, so the clamp and the hold-while-idle behaviour both act on the output register. The stimulus provokes this by placing directed saturating pixels, such as pure blue and pure red, directly before idle cycles. It also mixes a random valid duty cycle into the random pixel stream. Every cycle is judged against an integer model: a valid cycle must show the clamped value, and the idle cycles after it must repeat exactly that value.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

    localparam int PIX_W      = 8;
    localparam int FRAC_W     = 14;
    localparam int COEF_W     = FRAC_W + 1;
    localparam int PROD_W     = PIX_W + 1 + COEF_W;
    localparam int ACC_W      = PROD_W + 2;
    localparam int CHROMA_OFS = 128;
    localparam int PIPE_DEPTH = 3;
    localparam int N_CHAN     = 3;

    typedef logic        [PIX_W-1:0]  pix_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef struct packed {
        prod_t prod_r;
        prod_t prod_g;
        prod_t prod_b;
        acc_t  sum;
        pix_t  res;
    } chan_state_t;

    // Quantised weights: row = output channel (0 luma, 1 blue diff, 2 red diff)
    // column = input component (0 red, 1 green, 2 blue)
    function automatic coef_t weight(input int ch, input int col);
        coef_t w;
        case (ch * 3 + col)
            0: w = 15'sd4899;
            1: w = 15'sd9617;
            2: w = 15'sd1868;
            3: w = -15'sd2764;
            4: w = -15'sd5428;
            5: w = 15'sd8192;
            6: w = 15'sd8192;
            7: w = -15'sd6860;
            8: w = -15'sd1332;
            default: w = '0;
        endcase
        return w;
    endfunction

    function automatic int chan_offset(input int ch);
        return (ch == 0) ? 0 : CHROMA_OFS;
    endfunction

endpackage

// File: rtl/ycc_valid_pipe.sv
module ycc_valid_pipe
    import ycc_pkg::*;
#(
    parameter int DEPTH = PIPE_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    output logic [DEPTH-1:0] stage_vld_o
);

    logic [DEPTH-1:0] vld_d, vld_q;

    always_comb begin
        vld_d = {vld_q[DEPTH-2:0], vld_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    assign stage_vld_o = vld_q;

    AST_VLD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q[0] |=> vld_q[1]); // R2

endmodule

// File: rtl/ycc_channel.sv
module ycc_channel
    import ycc_pkg::*;
#(
    parameter coef_t K_R    = '0,
    parameter coef_t K_G    = '0,
    parameter coef_t K_B    = '0,
    parameter int    OFFSET = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_mul_i,
    input  logic ld_sum_i,
    input  logic ld_out_i,
    input  pix_t r_i,
    input  pix_t g_i,
    input  pix_t b_i,
    output pix_t res_o
);

    localparam acc_t BIAS    = acc_t'((OFFSET << FRAC_W) + (1 << (FRAC_W - 1)));
    localparam acc_t PIX_MAX = acc_t'((1 << PIX_W) - 1);

    chan_state_t st_d, st_q;
    acc_t        quot;

    assign quot = st_q.sum >>> FRAC_W;

    always_comb begin
        st_d = st_q;
        if (ld_mul_i) begin
            st_d.prod_r = prod_t'(signed'({1'b0, r_i})) * prod_t'(K_R);
            st_d.prod_g = prod_t'(signed'({1'b0, g_i})) * prod_t'(K_G);
            st_d.prod_b = prod_t'(signed'({1'b0, b_i})) * prod_t'(K_B);
        end
        if (ld_sum_i) begin
            st_d.sum = acc_t'(st_q.prod_r) + acc_t'(st_q.prod_g)
                     + acc_t'(st_q.prod_b) + BIAS;
        end
        if (ld_out_i) begin
            if (quot < 0)             st_d.res = '0;
            else if (quot > PIX_MAX)  st_d.res = pix_t'(PIX_MAX);
            else                      st_d.res = quot[PIX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o = st_q.res;

    AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_out_i && quot > PIX_MAX) |=> (res_o == pix_t'(PIX_MAX))); // R5
    AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_out_i && quot < 0) |=> (res_o == '0)); // R5

endmodule

// File: rtl/rgb2ycc_conv.sv
module rgb2ycc_conv
    import ycc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_r,
    input  logic [7:0] in_g,
    input  logic [7:0] in_b,
    output logic       out_valid,
    output logic [7:0] out_y,
    output logic [7:0] out_cb,
    output logic [7:0] out_cr
);

    logic [PIPE_DEPTH-1:0] stage_vld;
    pix_t                  chan_res [N_CHAN];

    ycc_valid_pipe #(.DEPTH(PIPE_DEPTH)) u_vld (
        .clk         (clk),
        .rst_n       (rst_n),
        .vld_i       (in_valid),
        .stage_vld_o (stage_vld)
    );

    for (genvar ch = 0; ch < N_CHAN; ch++) begin : g_chan
        ycc_channel #(
            .K_R    (weight(ch, 0)),
            .K_G    (weight(ch, 1)),
            .K_B    (weight(ch, 2)),
            .OFFSET (chan_offset(ch))
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_mul_i (in_valid),
            .ld_sum_i (stage_vld[0]),
            .ld_out_i (stage_vld[1]),
            .r_i      (in_r),
            .g_i      (in_g),
            .b_i      (in_b),
            .res_o    (chan_res[ch])
        );
    end

    assign out_valid = stage_vld[PIPE_DEPTH-1];
    assign out_y     = chan_res[0];
    assign out_cb    = chan_res[1];
    assign out_cr    = chan_res[2];

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_y) && $stable(out_cb) && $stable(out_cr))); // R6
    AST_GREY_NEUTRAL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_r == in_g && in_g == in_b) |-> ##3
        (out_y == $past(in_r, 3) && out_cb == 8'd128 && out_cr == 8'd128)); // R8

endmodule

// File: tb/rgb2ycc_conv_tb.sv
module rgb2ycc_conv_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_r = '0, in_g = '0, in_b = '0;
    logic       out_valid;
    logic [7:0] out_y, out_cb, out_cr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // history of driven inputs: index 0 newest
    logic       h_v [4];
    logic [7:0] h_r [4], h_g [4], h_b [4];
    logic [7:0] hold_y = '0, hold_cb = '0, hold_cr = '0;

    always #4 clk = ~clk;

    rgb2ycc_conv u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
    );

    function automatic int model(input int kr, input int kg, input int kb,
                                 input int ofs, input int r, input int g, input int b);
        int s;
        s = kr * r + kg * g + kb * b + ofs * 16384 + 8192;
        s = s >>> 14;
        if (s < 0)   s = 0;
        if (s > 255) s = 255;
        return s;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // called at a negedge: compare outputs against the pixel driven three negedges ago
    task automatic step(input logic v, input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
        int ey, ecb, ecr;
        check("R2/R9 out_valid", int'(out_valid), int'(h_v[2]));
        if (h_v[2]) begin
            ey  = model(4899, 9617, 1868, 0, h_r[2], h_g[2], h_b[2]);
            ecb = model(-2764, -5428, 8192, 128, h_r[2], h_g[2], h_b[2]);
            ecr = model(8192, -6860, -1332, 128, h_r[2], h_g[2], h_b[2]);
            if (h_r[2] == h_g[2] && h_g[2] == h_b[2]) begin
                check("R8 grey Y", out_y, h_r[2]);
                check("R8 grey Cb", out_cb, 128);
            end
            if (ecb == 255 || ecr == 255 || ey == 255) begin
                check("R5 clamp Cb", out_cb, ecb);
                check("R5 clamp Cr", out_cr, ecr);
            end
            check("R1 Y", out_y, ey);
            check("R3 Cb", out_cb, ecb);
            check("R4 Cr", out_cr, ecr);
            hold_y = 8'(ey); hold_cb = 8'(ecb); hold_cr = 8'(ecr);
        end else begin
            check("R6 hold Y", out_y, hold_y);
            check("R6 hold Cb", out_cb, hold_cb);
            check("R6 hold Cr", out_cr, hold_cr);
        end
        for (int i = 3; i > 0; i--) begin
            h_v[i] = h_v[i-1]; h_r[i] = h_r[i-1]; h_g[i] = h_g[i-1]; h_b[i] = h_b[i-1];
        end
        h_v[0] = v; h_r[0] = r; h_g[0] = g; h_b[0] = b;
        in_valid = v; in_r = r; in_g = g; in_b = b;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            h_v[i] = 1'b0; h_r[i] = '0; h_g[i] = '0; h_b[i] = '0;
        end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        check("R7 out_valid", out_valid, 0);
        check("R7 out_y", out_y, 0);
        check("R7 out_cb", out_cb, 0);
        check("R7 out_cr", out_cr, 0);

        // directed corners; saturating pixels followed by bubbles (R5 with R6)
        step(1, 8'd0,   8'd0,   8'd0);
        step(1, 8'd255, 8'd255, 8'd255);
        step(1, 8'd0,   8'd0,   8'd255);
        step(0, 8'd9,   8'd77,  8'd200);
        step(0, 8'd255, 8'd0,   8'd0);
        step(1, 8'd255, 8'd0,   8'd0);
        step(0, 8'd1,   8'd2,   8'd3);
        step(0, 8'd50,  8'd60,  8'd70);
        step(0, 8'd0,   8'd0,   8'd0);
        step(1, 8'd0,   8'd255, 8'd0);
        step(1, 8'd128, 8'd128, 8'd128);
        step(1, 8'd1,   8'd1,   8'd1);
        step(1, 8'd255, 8'd255, 8'd0);
        step(1, 8'd0,   8'd255, 8'd255);
        // R9 back-to-back burst of random pixels
        for (int i = 0; i < 200; i++)
            step(1, 8'($urandom), 8'($urandom), 8'($urandom));
        // random valid duty cycle with random pixels and greys
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] rr;
            rr = 8'($urandom);
            if (($urandom % 8) == 0)
                step(($urandom % 4) != 0, rr, rr, rr);
            else
                step(($urandom % 4) != 0, rr, 8'($urandom), 8'($urandom));
        end
        for (int i = 0; i < 4; i++) step(0, 8'd0, 8'd0, 8'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule